// File: doc/BRIEF.md
# Raster Sync Timing Generator with Shift-Register Position Counters

This block produces the horizontal and vertical timing for a monochrome raster that a standard VGA monitor accepts: 576 visible pixels per line and 455 visible lines by default. It runs on an externally supplied pixel clock. It drives horizontal and vertical blanking, horizontal and vertical sync, a one-clock line-end strobe and a one-clock frame-end strobe. A pixel fetch and serializer elsewhere in the chip use these outputs to frame the pixel stream.

Neither axis counts in binary. Each axis keeps its position in a 10-bit maximal-length shift register with XNOR feedback, which starts from a nonzero seed. Each raster event is found by a full-width equality match against the register state for that position. Those states are computed at elaboration from plain integer positions. Per axis, a small four-phase state machine sits behind the matches: ACTIVE, FRONT (blanked, before sync), SYNC, BACK (blanked, after sync). Its registered state gives glitch-free blank and sync outputs. The transitions are ACTIVE→FRONT on the blank match, FRONT→SYNC on the sync-start match, SYNC→BACK on the sync-end match, and BACK→ACTIVE on the end-of-axis match.

The horizontal axis steps on every clock. The vertical axis steps only on the clock that ends a line. On the end-of-axis match the register reloads the seed. Each match is taken one position early, so every flag changes on the edge that enters the named position.

Top module: `vga_lfsr_timing`

## Requirements
- R1: While reset is asserted and right after it, hblank and vblank are 0, both syncs are inactive, line_end and frame_end are 0, and the raster is at pixel 0 of line 0.
- R2: Every line lasts H_TOTAL clocks. hblank is 1 exactly for pixel positions H_BLANK to H_TOTAL-1 and 0 for positions 0 to H_BLANK-1.
- R3: hsync is active exactly for pixel positions H_SYNC_ON to H_SYNC_OFF-1, which always lie inside hblank.
- R4: vblank is 1 exactly for lines V_BLANK to V_TOTAL-1 of the frame.
- R5: vsync is active exactly for lines V_SYNC_ON to V_SYNC_OFF-1, which always lie inside vblank.
- R6: line_end is 1 for exactly one clock, at pixel position H_TOTAL-1 of each line, and is 0 at every other position.
- R7: frame_end is 1 only at pixel H_TOTAL-1 of line V_TOTAL-1. It is never 1 without line_end.
- R8: With SYNC_HIGH = 0 (the default), an active sync is driven 0 and an idle sync is driven 1. With SYNC_HIGH = 1 the levels are inverted.
- R9: vblank and vsync change only on the clock edge that follows a cycle with line_end = 1.
- R10: After line V_TOTAL-1 the raster goes back to line 0, and every later frame repeats the first frame cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | output | 1 | Horizontal sync, polarity set by SYNC_HIGH |
| vsync | output | 1 | Vertical sync, polarity set by SYNC_HIGH |
| hblank | output | 1 | High outside the visible pixels of a line |
| vblank | output | 1 | High on lines outside the visible area |
| line_end | output | 1 | High on the last pixel clock of each line |
| frame_end | output | 1 | High on the last pixel clock of each frame |

## Verification
Because each match is decoded one position early, the blank and sync flags take their new value in the same cycle that the raster enters the named position. The strobes are combinational from the position registers, so they are valid in that cycle as well. The vertical flags change one clock after the line-end cycle, at pixel 0 of the new line. The bench holds a reference pixel and line number counted from the first edge after reset is released. It queues the expected value of every output for each cycle and samples on the falling clock edge, so each comparison falls half a period after the edge that changed the output. A default-sized instance and a reduced instance (inverted sync polarity) are both compared, and the reduced instance runs two full frames to cover the frame wrap.

// File: rtl/vga_lfsr_pkg.sv
package vga_lfsr_pkg;

    localparam int LFSR_W = 10;
    // Second feedback tap (1-based) of x^10 + x^7 + 1.
    localparam int LFSR_TAP = 7;
    localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } axis_phase_e;

    // One shift with XNOR feedback; the all-ones word is the only stuck state.
    function automatic lfsr_t lfsr_next(input lfsr_t s);
        return {s[LFSR_W-2:0], ~(s[LFSR_W-1] ^ s[LFSR_TAP-1])};
    endfunction

    // Register contents after n steps from the seed.
    function automatic lfsr_t lfsr_at(input int n);
        lfsr_t s;
        s = LFSR_SEED;
        for (int i = 0; i < n; i++) begin
            s = lfsr_next(s);
        end
        return s;
    endfunction

endpackage

// File: rtl/lfsr_pos_counter.sv
module lfsr_pos_counter
    import vga_lfsr_pkg::*;
#(
    parameter int TOTAL = 736
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    output lfsr_t state,
    output logic  at_end
);

    localparam lfsr_t END_STATE = lfsr_at(TOTAL - 1);

    assign at_end = (state == END_STATE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LFSR_SEED;
        end else if (adv) begin
            state <= at_end ? LFSR_SEED : lfsr_next(state);
        end
    end

endmodule

// File: rtl/axis_event_decoder.sv
module axis_event_decoder
    import vga_lfsr_pkg::*;
#(
    parameter int BLANK_AT = 576,
    parameter int SYNC_ON  = 600,
    parameter int SYNC_OFF = 688
) (
    input  lfsr_t      state,
    output logic [2:0] hit
);

    localparam int N_EV = 3;

    // Each flag is decoded one position before it takes effect.
    function automatic int ev_pos(input int g);
        case (g)
            0:       return BLANK_AT - 1;
            1:       return SYNC_ON - 1;
            default: return SYNC_OFF - 1;
        endcase
    endfunction

    for (genvar g = 0; g < N_EV; g++) begin : g_match
        localparam lfsr_t MATCH = lfsr_at(ev_pos(g));
        assign hit[g] = (state == MATCH);
    end

endmodule

// File: rtl/axis_phase_fsm.sv
module axis_phase_fsm
    import vga_lfsr_pkg::*;
#(
    parameter bit SYNC_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic hit_blank,
    input  logic hit_sync_on,
    input  logic hit_sync_off,
    input  logic hit_end,
    output logic blank,
    output logic sync
);

    axis_phase_e phase_q;
    axis_phase_e phase_d;

    always_comb begin
        phase_d = phase_q;
        if (adv) begin
            unique case (phase_q)
                PH_ACTIVE: if (hit_blank)    phase_d = PH_FRONT;
                PH_FRONT:  if (hit_sync_on)  phase_d = PH_SYNC;
                PH_SYNC:   if (hit_sync_off) phase_d = PH_BACK;
                PH_BACK:   if (hit_end)      phase_d = PH_ACTIVE;
                default:                     phase_d = PH_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_ACTIVE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        blank = (phase_q != PH_ACTIVE);
        sync  = (phase_q == PH_SYNC) ? SYNC_HIGH : ~SYNC_HIGH;
    end

endmodule

// File: rtl/vga_lfsr_timing.sv
module vga_lfsr_timing
    import vga_lfsr_pkg::*;
#(
    parameter int H_TOTAL    = 736,
    parameter int H_BLANK    = 576,
    parameter int H_SYNC_ON  = 600,
    parameter int H_SYNC_OFF = 688,
    parameter int V_TOTAL    = 525,
    parameter int V_BLANK    = 455,
    parameter int V_SYNC_ON  = 480,
    parameter int V_SYNC_OFF = 482,
    parameter bit SYNC_HIGH  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output logic hsync,
    output logic vsync,
    output logic hblank,
    output logic vblank,
    output logic line_end,
    output logic frame_end
);

    lfsr_t      h_state;
    lfsr_t      v_state;
    logic       h_end;
    logic       v_end;
    logic [2:0] h_hit;
    logic [2:0] v_hit;

    // Horizontal axis: steps every pixel clock.
    lfsr_pos_counter #(.TOTAL(H_TOTAL)) u_h_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (1'b1),
        .state  (h_state),
        .at_end (h_end)
    );

    axis_event_decoder #(
        .BLANK_AT (H_BLANK),
        .SYNC_ON  (H_SYNC_ON),
        .SYNC_OFF (H_SYNC_OFF)
    ) u_h_dec (
        .state (h_state),
        .hit   (h_hit)
    );

    axis_phase_fsm #(.SYNC_HIGH(SYNC_HIGH)) u_h_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv          (1'b1),
        .hit_blank    (h_hit[0]),
        .hit_sync_on  (h_hit[1]),
        .hit_sync_off (h_hit[2]),
        .hit_end      (h_end),
        .blank        (hblank),
        .sync         (hsync)
    );

    // Vertical axis: steps once per line, on the last pixel clock.
    lfsr_pos_counter #(.TOTAL(V_TOTAL)) u_v_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (h_end),
        .state  (v_state),
        .at_end (v_end)
    );

    axis_event_decoder #(
        .BLANK_AT (V_BLANK),
        .SYNC_ON  (V_SYNC_ON),
        .SYNC_OFF (V_SYNC_OFF)
    ) u_v_dec (
        .state (v_state),
        .hit   (v_hit)
    );

    axis_phase_fsm #(.SYNC_HIGH(SYNC_HIGH)) u_v_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv          (h_end),
        .hit_blank    (v_hit[0]),
        .hit_sync_on  (v_hit[1]),
        .hit_sync_off (v_hit[2]),
        .hit_end      (v_end),
        .blank        (vblank),
        .sync         (vsync)
    );

    assign line_end  = h_end;
    assign frame_end = h_end & v_end;

endmodule

// File: rtl/vga_lfsr_timing_chk.sv
module vga_lfsr_timing_chk #(
    parameter int H_TOTAL   = 736,
    parameter bit SYNC_HIGH = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic vsync,
    input logic hblank,
    input logic vblank,
    input logic line_end,
    input logic frame_end
);

    localparam int GAP_W = 16;

    logic [GAP_W-1:0] gap;

    // Clocks since reset or since the last line end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (line_end) begin
            gap <= '0;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    a_r6_line_length: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> (gap == GAP_W'(H_TOTAL - 1)));

    a_r3_hsync_in_hblank: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync == SYNC_HIGH) |-> hblank);

    a_r5_vsync_in_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync == SYNC_HIGH) |-> vblank);

    a_r7_frame_implies_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> line_end);

    a_r2_hblank_clears_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hblank) |-> $past(line_end));

    a_r9_vblank_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(vblank));

    a_r9_vsync_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(vsync));

endmodule

bind vga_lfsr_timing vga_lfsr_timing_chk #(
    .H_TOTAL   (H_TOTAL),
    .SYNC_HIGH (SYNC_HIGH)
) u_chk (.*);

// File: tb/vga_lfsr_timing_bench.sv
module vga_lfsr_timing_bench;

    // Reduced raster for the frame-level scoreboard.
    localparam int HT = 40, HB = 30, HS0 = 33, HS1 = 36;
    localparam int VT = 12, VB = 9,  VS0 = 10, VS1 = 11;
    localparam int FRAMES = 2;
    // Default raster, horizontal behaviour only.
    localparam int DHT = 736, DHB = 576, DHS0 = 600, DHS1 = 688;
    localparam int DLINES = 2;

    typedef struct packed {
        logic hb, hs, vb, vs, le, fe;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic hs, vs, hb, vb, le, fe;
    logic dhs, dvs, dhb, dvb, dle, dfe;

    vga_lfsr_timing #(
        .H_TOTAL(HT), .H_BLANK(HB), .H_SYNC_ON(HS0), .H_SYNC_OFF(HS1),
        .V_TOTAL(VT), .V_BLANK(VB), .V_SYNC_ON(VS0), .V_SYNC_OFF(VS1),
        .SYNC_HIGH(1'b1)
    ) u_vga_lfsr_timing (
        .clk(clk), .rst_n(rst_n), .hsync(hs), .vsync(vs),
        .hblank(hb), .vblank(vb), .line_end(le), .frame_end(fe)
    );

    vga_lfsr_timing u_vga_lfsr_timing_full (
        .clk(clk), .rst_n(rst_n), .hsync(dhs), .vsync(dvs),
        .hblank(dhb), .vblank(dvb), .line_end(dle), .frame_end(dfe)
    );

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit done = 1'b0;
    int nsamp = 0;
    exp_t expq[$];

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %b expected %b at sample %0d", req, what, act, exp, nsamp);
        end
    endtask

    // Driver: expected outputs of the reduced raster, one item per clock.
    task automatic push_frames(input int nframes);
        for (int f = 0; f < nframes; f++) begin
            for (int l = 0; l < VT; l++) begin
                for (int p = 0; p < HT; p++) begin
                    exp_t e;
                    e.hb = (p >= HB);
                    e.hs = (p >= HS0 && p < HS1);      // active high here
                    e.vb = (l >= VB);
                    e.vs = (l >= VS0 && l < VS1);
                    e.le = (p == HT - 1);
                    e.fe = (p == HT - 1) && (l == VT - 1);
                    expq.push_back(e);
                end
            end
        end
    endtask

    // Monitor: samples half a period after each active edge.
    always @(negedge clk) begin
        if (running) begin
            if (expq.size() > 0) begin
                exp_t e;
                bit later;
                e = expq.pop_front();
                later = (nsamp >= HT * VT);
                chk(later ? "R10" : "R2", "hblank", hb, e.hb);
                chk(later ? "R10" : "R3", "hsync (R8 active high)", hs, e.hs);
                chk(later ? "R10" : "R4", "vblank (R9 timing)", vb, e.vb);
                chk(later ? "R10" : "R5", "vsync (R9 timing)", vs, e.vs);
                chk(later ? "R10" : "R6", "line_end", le, e.le);
                chk(later ? "R10" : "R7", "frame_end", fe, e.fe);
            end
            if (nsamp < DHT * DLINES) begin
                int p;
                p = nsamp % DHT;
                chk("R2", "default hblank", dhb, p >= DHB);
                chk("R8", "default hsync active low", dhs, !(p >= DHS0 && p < DHS1));
                chk("R6", "default line_end", dle, p == DHT - 1);
                chk("R4", "default vblank line 0", dvb, 1'b0);
                chk("R8", "default vsync idle high", dvs, 1'b1);
                chk("R7", "default frame_end", dfe, 1'b0);
            end
            nsamp++;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state, both instances
        chk("R1", "hblank in reset", hb, 1'b0);
        chk("R1", "vblank in reset", vb, 1'b0);
        chk("R1", "hsync idle in reset", hs, 1'b0);
        chk("R1", "vsync idle in reset", vs, 1'b0);
        chk("R1", "line_end in reset", le, 1'b0);
        chk("R1", "frame_end in reset", fe, 1'b0);
        chk("R1", "default hsync idle in reset", dhs, 1'b1);
        chk("R1", "default hblank in reset", dhb, 1'b0);
        push_frames(FRAMES);
        @(posedge clk);
        #5;
        rst_n = 1'b1;
        running = 1'b1;
        wait (expq.size() == 0 && nsamp >= DHT * DLINES);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule